// File: doc/BRIEF.md
# Paged Virtual Address Translator

The block turns a 32-bit virtual byte address into a 30-bit physical address. It does this by walking one level of page tables kept in memory. A request carries the virtual address. The two top address bits select a region, and each usable region has its own page-table base and length inputs. The 21 bits between the region bits and the 9-bit page offset form the virtual page number.

If the region is usable and the page number lies inside that region's table, the block reads one longword entry from memory. The entry's address is the table base plus four times the page number. Bit 31 of the entry marks the page as resident, and bits 20:0 hold the physical frame number. A resident page gives a physical address made of the frame number with the page offset appended below it. Every other outcome is reported as a fault with a 2-bit code.

The CPU side uses a valid/ready request and a valid/ready response. The memory side is a single read port: the block holds its request until read data returns. The block handles one translation at a time.

Top module: `vat_translator`

## Requirements
- R1: After reset, req_ready_o is 1, mem_req_o is 0 and rsp_valid_o is 0.
- R2: Bits 31:30 of the virtual address select table slot 0, 1 or 2. The slot's base is taken from tbl_base_i[30*s +: 30] and its length from tbl_len_i[22*s +: 22].
- R3: For an in-range page the block raises mem_req_o one cycle after accepting the request. mem_addr_o equals (base + 4*vpn) modulo 2^30, where vpn is bits 29:9 of the virtual address. Request and address hold steady until the cycle mem_rvalid_i is seen.
- R4: An entry with bit 31 set gives rsp_fault_o = 0 and rsp_pa_o = {entry[20:0], va[8:0]}. Entry bits 30:21 have no effect on the result.
- R5: An entry with bit 31 clear gives rsp_fault_o = 2 (page not resident) and rsp_pa_o = 0.
- R6: A page number at or above the selected length gives rsp_fault_o = 1 and rsp_pa_o = 0. The response appears one cycle after acceptance, and no memory read is issued.
- R7: Region value 3 always gives rsp_fault_o = 3 and rsp_pa_o = 0 one cycle after acceptance, with no memory read.
- R8: A response stays valid and unchanged until rsp_ready_i is sampled high. req_ready_o is low from acceptance until the response is taken.
- R9: The length check is exact. A page number of length-1 translates, a page number equal to length faults, and a length of 0 faults every page of that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_base_i | input | 90 | Packed page-table base addresses, one 30-bit field per slot |
| tbl_len_i | input | 66 | Packed table lengths in entries, one 22-bit field per slot |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_va_i | input | 32 | Virtual byte address |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Result consumed |
| rsp_pa_o | output | 30 | Physical address, zero on a fault |
| rsp_fault_o | output | 2 | 0 none, 1 length, 2 not resident, 3 reserved region |
| mem_req_o | output | 1 | Page-table entry read request |
| mem_addr_o | output | 30 | Byte address of the entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page-table entry longword |

## Verification
The bench builds the block with its default parameters: three table slots and one reserved region value. It programs the slots to expose every length corner. Slot 0 has a short table of 16 entries, so both the last valid page and the first page past the end can be reached. Slot 1 has a full 2^21-entry table whose base sits near the top of physical space, so the entry address wraps around. Slot 2 has length zero. Read latencies and response back-pressure are varied so that the hold behaviour on both handshakes is exercised.

// File: rtl/vat_pkg.sv
package vat_pkg;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_LENGTH = 2'd1,
      FLT_ABSENT = 2'd2,
      FLT_RSVD   = 2'd3
   } vat_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_REPLY = 2'd2
   } vat_state_e;

endpackage

// File: rtl/vat_table_sel.sv
module vat_table_sel #(
   parameter int unsigned NUM_TABLES = 3,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned BASE_W     = 30,
   parameter int unsigned LEN_W      = 22
) (
   input  logic [SEL_W-1:0]             sel_i,
   input  logic [NUM_TABLES*BASE_W-1:0] bases_i,
   input  logic [NUM_TABLES*LEN_W-1:0]  lens_i,
   output logic [BASE_W-1:0]            base_o,
   output logic [LEN_W-1:0]             len_o,
   output logic                         rsvd_o
);
   localparam int unsigned SLOTS = 1 << SEL_W;

   logic [BASE_W-1:0] base_a [SLOTS];
   logic [LEN_W-1:0]  len_a  [SLOTS];
   logic [SLOTS-1:0]  present;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NUM_TABLES) begin : g_used
         assign base_a[g]  = bases_i[g*BASE_W +: BASE_W];
         assign len_a[g]   = lens_i[g*LEN_W +: LEN_W];
         assign present[g] = 1'b1;
      end else begin : g_rsvd
         assign base_a[g]  = '0;
         assign len_a[g]   = '0;
         assign present[g] = 1'b0;
      end
   end

   assign base_o = base_a[sel_i];
   assign len_o  = len_a[sel_i];
   assign rsvd_o = ~present[sel_i];

endmodule

// File: rtl/vat_walk_check.sv
module vat_walk_check import vat_pkg::*; #(
   parameter int unsigned VPN_W  = 21,
   parameter int unsigned BASE_W = 30,
   parameter int unsigned LEN_W  = 22
) (
   input  logic [VPN_W-1:0]  vpn_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              rsvd_i,
   output logic [BASE_W-1:0] entry_addr_o,
   output vat_fault_e        fault_o
);
   localparam int unsigned IDX_W = VPN_W + 2;

   logic [IDX_W-1:0] byte_idx;
   logic             beyond;

   assign byte_idx     = {vpn_i, 2'b00};
   assign entry_addr_o = base_i + BASE_W'(byte_idx);
   assign beyond       = LEN_W'(vpn_i) >= len_i;

   always_comb begin
      if (rsvd_i)      fault_o = FLT_RSVD;
      else if (beyond) fault_o = FLT_LENGTH;
      else             fault_o = FLT_NONE;
   end

endmodule

// File: rtl/vat_pte_decode.sv
module vat_pte_decode #(
   parameter int unsigned PFN_W = 21,
   parameter int unsigned OFS_W = 9
) (
   input  logic                   valid_bit_i,
   input  logic [PFN_W-1:0]       pfn_i,
   input  logic [OFS_W-1:0]       ofs_i,
   output logic                   present_o,
   output logic [PFN_W+OFS_W-1:0] pa_o
);
   assign present_o = valid_bit_i;
   assign pa_o      = {pfn_i, ofs_i};
endmodule

// File: rtl/vat_translator.sv
module vat_translator import vat_pkg::*; #(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PAGE_OFS_W = 9,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned NUM_TABLES = 3,
   parameter int unsigned PFN_W      = 21,
   parameter int unsigned PTE_W      = 32,
   parameter int unsigned VALID_BIT  = 31,
   parameter int unsigned PA_W       = PFN_W + PAGE_OFS_W,
   parameter int unsigned LEN_W      = VA_W - SEL_W - PAGE_OFS_W + 1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_TABLES*PA_W-1:0]  tbl_base_i,
   input  logic [NUM_TABLES*LEN_W-1:0] tbl_len_i,
   input  logic                        req_valid_i,
   output logic                        req_ready_o,
   input  logic [VA_W-1:0]             req_va_i,
   output logic                        rsp_valid_o,
   input  logic                        rsp_ready_i,
   output logic [PA_W-1:0]             rsp_pa_o,
   output logic [1:0]                  rsp_fault_o,
   output logic                        mem_req_o,
   output logic [PA_W-1:0]             mem_addr_o,
   input  logic                        mem_rvalid_i,
   input  logic [PTE_W-1:0]            mem_rdata_i
);
   localparam int unsigned VPN_W = VA_W - SEL_W - PAGE_OFS_W;

   if (PA_W != PFN_W + PAGE_OFS_W) begin : g_bad_pa
      $error("PA_W must equal PFN_W + PAGE_OFS_W");
   end
   if (LEN_W != VPN_W + 1) begin : g_bad_len
      $error("LEN_W must be one wider than the page number");
   end
   if (NUM_TABLES < 1 || NUM_TABLES > (1 << SEL_W)) begin : g_bad_tables
      $error("NUM_TABLES out of range for SEL_W");
   end
   if (VALID_BIT >= PTE_W || PFN_W > VALID_BIT) begin : g_bad_pte
      $error("entry layout does not fit PTE_W");
   end
   if (VPN_W + 2 > PA_W) begin : g_bad_idx
      $error("table index does not fit the physical address");
   end

   vat_state_e            state_q;
   logic [PAGE_OFS_W-1:0] ofs_q;
   logic [PA_W-1:0]       addr_q;
   logic [PA_W-1:0]       pa_q;
   vat_fault_e            fault_q;

   logic [SEL_W-1:0]      sel;
   logic [VPN_W-1:0]      vpn;
   logic [PA_W-1:0]       tbl_base;
   logic [LEN_W-1:0]      tbl_len;
   logic                  rsvd;
   logic [PA_W-1:0]       entry_addr;
   vat_fault_e            chk_fault;
   logic                  pte_present;
   logic [PA_W-1:0]       pte_pa;
   logic                  unused_pte_bits;

   assign sel = req_va_i[VA_W-1 -: SEL_W];
   assign vpn = req_va_i[PAGE_OFS_W +: VPN_W];

   vat_table_sel #(
      .NUM_TABLES (NUM_TABLES),
      .SEL_W      (SEL_W),
      .BASE_W     (PA_W),
      .LEN_W      (LEN_W)
   ) u_sel (
      .sel_i   (sel),
      .bases_i (tbl_base_i),
      .lens_i  (tbl_len_i),
      .base_o  (tbl_base),
      .len_o   (tbl_len),
      .rsvd_o  (rsvd)
   );

   vat_walk_check #(
      .VPN_W  (VPN_W),
      .BASE_W (PA_W),
      .LEN_W  (LEN_W)
   ) u_chk_walk (
      .vpn_i        (vpn),
      .base_i       (tbl_base),
      .len_i        (tbl_len),
      .rsvd_i       (rsvd),
      .entry_addr_o (entry_addr),
      .fault_o      (chk_fault)
   );

   vat_pte_decode #(
      .PFN_W (PFN_W),
      .OFS_W (PAGE_OFS_W)
   ) u_dec (
      .valid_bit_i (mem_rdata_i[VALID_BIT]),
      .pfn_i       (mem_rdata_i[PFN_W-1:0]),
      .ofs_i       (ofs_q),
      .present_o   (pte_present),
      .pa_o        (pte_pa)
   );

   assign unused_pte_bits = ^mem_rdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         ofs_q   <= '0;
         addr_q  <= '0;
         pa_q    <= '0;
         fault_q <= FLT_NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  ofs_q  <= req_va_i[PAGE_OFS_W-1:0];
                  addr_q <= entry_addr;
                  if (chk_fault != FLT_NONE) begin
                     fault_q <= chk_fault;
                     pa_q    <= '0;
                     state_q <= ST_REPLY;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_rvalid_i) begin
                  if (pte_present) begin
                     pa_q    <= pte_pa;
                     fault_q <= FLT_NONE;
                  end else begin
                     pa_q    <= '0;
                     fault_q <= FLT_ABSENT;
                  end
                  state_q <= ST_REPLY;
               end
            end
            ST_REPLY: begin
               if (rsp_ready_i) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign mem_req_o   = (state_q == ST_FETCH);
   assign mem_addr_o  = addr_q;
   assign rsp_valid_o = (state_q == ST_REPLY);
   assign rsp_pa_o    = pa_q;
   assign rsp_fault_o = fault_q;

endmodule

// File: rtl/vat_checker.sv
module vat_checker #(
   parameter int unsigned PAGE_OFS_W = 9,
   parameter int unsigned SEL_W      = 2,
   parameter int unsigned NUM_TABLES = 3,
   parameter int unsigned PA_W       = 30
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  req_valid_i,
   input logic                  req_ready_o,
   input logic [SEL_W-1:0]      sel_i,
   input logic [PAGE_OFS_W-1:0] ofs_i,
   input logic                  rsp_valid_o,
   input logic                  rsp_ready_i,
   input logic [PA_W-1:0]       rsp_pa_o,
   input logic [1:0]            rsp_fault_o,
   input logic                  mem_req_o,
   input logic [PA_W-1:0]       mem_addr_o,
   input logic                  mem_rvalid_i
);
   logic [PAGE_OFS_W-1:0] ofs_seen;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ofs_seen <= '0;
      else if (req_valid_i && req_ready_o) ofs_seen <= ofs_i;
   end

   AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({req_ready_o, mem_req_o, rsp_valid_o}) == 1); // R8

   AST_READ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o)); // R3

   AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o)); // R8

   AST_RSVD_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i && req_ready_o && (32'(sel_i) >= NUM_TABLES) |=> rsp_valid_o && rsp_fault_o == 2'd3); // R7

   AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && rsp_fault_o != 2'd0 |-> rsp_pa_o == '0); // R5

   AST_OFS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o && rsp_fault_o == 2'd0 |-> rsp_pa_o[PAGE_OFS_W-1:0] == ofs_seen); // R4

   AST_READ_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && mem_rvalid_i |=> rsp_valid_o && (rsp_fault_o == 2'd0 || rsp_fault_o == 2'd2)); // R5

endmodule

bind vat_translator vat_checker #(
   .PAGE_OFS_W (PAGE_OFS_W),
   .SEL_W      (SEL_W),
   .NUM_TABLES (NUM_TABLES),
   .PA_W       (PA_W)
) u_vat_checker (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .req_ready_o  (req_ready_o),
   .sel_i        (req_va_i[VA_W-1 -: SEL_W]),
   .ofs_i        (req_va_i[PAGE_OFS_W-1:0]),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_ready_i  (rsp_ready_i),
   .rsp_pa_o     (rsp_pa_o),
   .rsp_fault_o  (rsp_fault_o),
   .mem_req_o    (mem_req_o),
   .mem_addr_o   (mem_addr_o),
   .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/tb_vat_translator.sv
module tb_vat_translator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [89:0] tbl_base;
   logic [65:0] tbl_len;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [29:0] rsp_pa;
   logic [1:0]  rsp_fault;
   logic        mem_req;
   logic [29:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = 32'hDEAD_BEEF;

   int checks = 0;
   int errors = 0;
   int reads  = 0;
   int phase  = 0;

   logic [29:0] base_a [3];
   logic [21:0] len_a  [3];

   initial begin
      base_a[0] = 30'h0001_0000; len_a[0] = 22'd16;
      base_a[1] = 30'h3FFF_FFF0; len_a[1] = 22'h20_0000;
      base_a[2] = 30'h0200_0000; len_a[2] = 22'd0;
   end
   assign tbl_base = {base_a[2], base_a[1], base_a[0]};
   assign tbl_len  = {len_a[2], len_a[1], len_a[0]};

   always #5 clk = ~clk;

   vat_translator dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .tbl_base_i   (tbl_base),
      .tbl_len_i    (tbl_len),
      .req_valid_i  (req_valid),
      .req_ready_o  (req_ready),
      .req_va_i     (req_va),
      .rsp_valid_o  (rsp_valid),
      .rsp_ready_i  (rsp_ready),
      .rsp_pa_o     (rsp_pa),
      .rsp_fault_o  (rsp_fault),
      .mem_req_o    (mem_req),
      .mem_addr_o   (mem_addr),
      .mem_rvalid_i (mem_rvalid),
      .mem_rdata_i  (mem_rdata)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] va, input logic [31:0] pte,
                                 output int fault, output logic [29:0] pa,
                                 output logic [29:0] addr, output bit rd);
      int region = int'(va[31:30]);
      int vpn    = int'(va[29:9]);
      pa = '0; addr = '0; rd = 0;
      if (region == 3) fault = 3;
      else if (vpn >= int'(len_a[region])) fault = 1;
      else begin
         rd    = 1;
         addr  = 30'((longint'(base_a[region]) + longint'(vpn) * 4) % (64'd1 << 30));
         if (pte[31]) begin fault = 0; pa = {pte[20:0], va[8:0]}; end
         else fault = 2;
      end
   endfunction

   // behavioural phase model: 0 idle, 1 reading, 2 answering
   always @(posedge clk) begin
      if (!rst_n) phase = 0;
      else begin
         if (mem_req && mem_rvalid) reads++;
         case (phase)
            0: if (req_valid) begin
                  int f; logic [29:0] p, a; bit r;
                  model(req_va, 32'h0, f, p, a, r);
                  phase = r ? 1 : 2;
               end
            1: if (mem_rvalid) phase = 2;
            default: if (rsp_ready) phase = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(req_ready == (phase == 0), "R8", "req_ready vs model", req_ready, phase == 0);
         check(mem_req == (phase == 1), "R3", "mem_req vs model", mem_req, phase == 1);
         check(rsp_valid == (phase == 2), "R8", "rsp_valid vs model", rsp_valid, phase == 2);
      end
   end

   task automatic run(input logic [31:0] va, input logic [31:0] pte,
                      input int lat, input int hold, input string tag);
      int f; logic [29:0] p, a; bit rd; int r0;
      model(va, pte, f, p, a, rd);
      r0 = reads;
      @(negedge clk);
      check(req_ready == 1'b1, "R8", {tag, " ready before request"}, req_ready, 1);
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0; req_va = 32'h5555_5555;
      if (rd) begin
         check(mem_req == 1'b1, "R3", {tag, " read raised"}, mem_req, 1);
         check(mem_addr == a, "R3", {tag, " entry address"}, mem_addr, a);
         for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(mem_req == 1'b1 && mem_addr == a, "R3", {tag, " read held"}, mem_addr, a);
         end
         mem_rvalid = 1'b1; mem_rdata = pte;
         @(negedge clk);
         mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      end
      check(rsp_valid == 1'b1, tag, "response valid", rsp_valid, 1);
      check(int'(rsp_fault) == f, tag, "fault code", rsp_fault, f);
      check(rsp_pa == p, tag, "physical address", rsp_pa, p);
      check(reads - r0 == (rd ? 1 : 0), rd ? "R3" : "R6", {tag, " read count"}, reads - r0, rd ? 1 : 0);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         check(rsp_valid && rsp_pa == p && int'(rsp_fault) == f, "R8",
               {tag, " response held"}, rsp_pa, p);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(!rsp_valid && req_ready, "R8", {tag, " back to idle"}, rsp_valid, 0);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0, "R1", "reset state",
            {req_ready, mem_req, rsp_valid}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && mem_req == 1'b0 && rsp_valid == 1'b0, "R1", "idle after reset",
            {req_ready, mem_req, rsp_valid}, 3'b100);

      // R2 R4: slot 0, resident page
      run({2'd0, 21'd5, 9'h1A3}, 32'h8001_2345, 2, 1, "R4");
      // R2 R3: slot 1 last page, entry address wraps past top
      run({2'd1, 21'h1F_FFFF, 9'h1FF}, 32'h801F_FFFF, 0, 0, "R2");
      // R9: last page inside a 16-entry table
      run({2'd0, 21'd15, 9'h000}, 32'h8000_0ABC, 1, 0, "R9");
      // R6 R9: first page past the end
      run({2'd0, 21'd16, 9'h010}, 32'h8000_0001, 0, 2, "R6");
      // R9: zero-length table
      run({2'd2, 21'd0, 9'h0FF}, 32'h8000_0001, 0, 0, "R9");
      // R7: reserved region
      run({2'd3, 21'd0, 9'h001}, 32'h8000_0001, 0, 1, "R7");
      // R5: not resident, frame bits ignored
      run({2'd1, 21'd7, 9'h0AA}, 32'h7FFF_FFFF, 4, 0, "R5");
      // R4: bits 30:21 of a resident entry have no effect
      run({2'd0, 21'd3, 9'h155}, 32'hFFE0_0042, 0, 3, "R4");
      // R2: slot 1 page 0, frame 0
      run({2'd1, 21'd0, 9'h000}, 32'h8000_0000, 3, 0, "R2");
      // R8: long back-pressure on a fault response
      run({2'd0, 21'h10_0000, 9'h0}, 32'h8000_0000, 0, 5, "R8");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule